// File: doc/BRIEF.md
# Serially Concatenated Convolutional Encoder

This block encodes a stream of information bits in fixed blocks of K bits. The first stage is a non-recursive two-state code with two identical 1+D generators. It turns each information bit into a pair of coded bits, so a block of K bits becomes 2K bits. These 2K bits are written into a block buffer in natural order. Once the whole block is in the buffer, it is read back in a permuted order given by the affine address sequence (A*j + B) mod 2K. Each bit read out passes through a two-state recursive accumulator with transfer function 1/(1+D). The accumulator produces one transmitted bit per bit read, so the overall rate is 1/2 and no bits are punctured.

The input side accepts bits with a valid/ready handshake. The output side presents bits with valid/ready and marks the final bit of each block. A single buffer holds the block. Input is therefore refused for the whole time a block is being read out. Both shift-register states start at zero for every block, and no tail bits are added. The multiplier A must be odd and coprime to 2K, and the defaults meet this.

Top module: `scc_encoder`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: For information bit u_i of a block (i = 0..K-1), coded positions 2i and 2i+1 both hold u_i XOR u_(i-1), where u_(-1) = 0.
- R3: Output bit j of a block (j = 0..2K-1) is taken from coded position (A*j + B) mod 2K.
- R4: Transmitted bit y_j equals the coded bit selected for step j XOR y_(j-1), where y_(-1) = 0.
- R5: out_valid stays 0 until the K-th input bit of a block has been accepted, and it is 1 in the cycle after that acceptance.
- R6: While a block is being read out, in_ready is 0 and bits offered on in_bit/in_valid are ignored, so they do not change any later output.
- R7: out_last is 1 on output step j = 2K-1 only, exactly 2K bits are output per block, and in_ready returns to 1 after the last bit is taken.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_bit holds its value, and the read position does not advance.
- R9: Each block is encoded independently: no outer or inner state carries over from the previous block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Information bit offered |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Encoder can accept a bit |
| out_valid | output | 1 | Transmitted bit available |
| out_bit | output | 1 | Transmitted bit |
| out_last | output | 1 | Last transmitted bit of the block |
| out_ready | input | 1 | Downstream takes the bit |

## Verification
The bench compares every block with a bit-exact model of the concatenated code. It uses blocks of all zeros, all ones, alternating bits and mixed bits. Any error in the 1+D outer code, the permutation step or the accumulator feedback shows up as flipped output bits.

- If the read started before the block was full, out_valid would rise too early.
- If the read ignored stalls, a bit would be lost or out_bit would change during a stall.
- If input were not blocked during readout, the junk bits offered during readout would corrupt the next block.
- If state were not cleared per block, the second of two consecutive blocks would carry the first block's final outer bit or accumulator value and come out wrong.

// File: rtl/scc_encoder.sv
module scc_encoder #(
  parameter int K = 8,
  parameter int A = 5,
  parameter int B = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  input  logic out_ready
);
  localparam int N      = 2 * K;
  localparam int AW     = $clog2(N);
  localparam int STEP_I = A % N;
  localparam int OFS_I  = B % N;

  logic [N-1:0]  buf_q;
  logic          draining;
  logic [AW-1:0] cnt;
  logic [AW-1:0] addr;
  logic          prev;
  logic          acc;
  logic [AW:0]   addr_sum;
  logic [AW-1:0] addr_nxt;
  logic          in_fire, out_fire, coded;

  assign in_ready  = !draining;
  assign out_valid = draining;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign coded     = in_bit ^ prev;
  assign out_bit   = buf_q[addr] ^ acc;
  assign out_last  = draining && (cnt == AW'(N - 1));

  assign addr_sum = {1'b0, addr} + STEP_I[AW:0];
  assign addr_nxt = (addr_sum >= N[AW:0]) ? AW'(addr_sum - N[AW:0]) : addr_sum[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q    <= '0;
      draining <= 1'b0;
      cnt      <= '0;
      addr     <= OFS_I[AW-1:0];
      prev     <= 1'b0;
      acc      <= 1'b0;
    end else if (in_fire) begin
      buf_q[{cnt[AW-2:0], 1'b0}] <= coded;
      buf_q[{cnt[AW-2:0], 1'b1}] <= coded;
      if (cnt == AW'(K - 1)) begin
        draining <= 1'b1;
        cnt      <= '0;
        prev     <= 1'b0;
        addr     <= OFS_I[AW-1:0];
        acc      <= 1'b0;
      end else begin
        cnt  <= cnt + 1'b1;
        prev <= in_bit;
      end
    end else if (out_fire) begin
      if (out_last) begin
        draining <= 1'b0;
        cnt      <= '0;
        acc      <= 1'b0;
        addr     <= OFS_I[AW-1:0];
      end else begin
        cnt  <= cnt + 1'b1;
        acc  <= out_bit;
        addr <= addr_nxt;
      end
    end
  end

  // R5
  full_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && cnt == AW'(K - 1)) |=> (out_valid && !in_ready));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(cnt)));

  // R7
  last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (in_ready && !out_valid));

  // R9
  state_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (!acc && !prev));

  // R6
  no_write_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (out_valid || in_ready) && $stable(buf_q));
endmodule

// File: tb/tb_scc_encoder.sv
module tb_scc_encoder;
  localparam int K = 8;
  localparam int A = 5;
  localparam int B = 3;
  localparam int N = 2 * K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  scc_encoder #(.K(K), .A(A), .B(B)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last), .out_ready(out_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [K-1:0] u);
    logic [N-1:0] v, y;
    logic p = 1'b0;
    for (int i = 0; i < K; i++) begin
      v[2*i]   = u[i] ^ (i == 0 ? 1'b0 : u[i-1]);
      v[2*i+1] = v[2*i];
    end
    for (int j = 0; j < N; j++) begin
      y[j] = v[(A*j + B) % N] ^ p;
      p = y[j];
    end
    return y;
  endfunction

  // R5: drives K bits, checking out_valid stays low until the last is taken
  task automatic send_block(input logic [K-1:0] u);
    for (int i = 0; i < K; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_bit   = u[i];
      while (!in_ready) @(negedge clk);
      check("R5 early valid", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 valid after fill", out_valid, 1);
  endtask

  // R2 R3 R4 R7 R8 R6: collects 2K bits with optional stalls and junk input
  task automatic recv_block(input logic [K-1:0] u, input bit stall, input bit junk);
    logic [N-1:0] exp;
    logic held;
    exp = model(u);
    for (int j = 0; j < N; j++) begin
      bit got = 1'b0;
      int t = 0;
      while (!got) begin
        if (t != 0 || j != 0) @(negedge clk);
        in_valid  = junk && (j < N - 1);
        in_bit    = j[0];
        out_ready = !(stall && ((j + t) % 3 == 0) && t < 2);
        if (junk) check("R6 ready low in readout", in_ready, 0);
        if (out_valid && !out_ready) begin
          held = out_bit;
          @(negedge clk);
          check("R8 valid held", out_valid, 1);
          check("R8 bit held", out_bit, held);
          t++;
          continue;
        end
        if (out_valid && out_ready) begin
          check($sformatf("R4 R3 R2 bit %0d", j), out_bit, exp[j]);
          check("R7 last flag", out_last, (j == N - 1));
          got = 1'b1;
        end
        t++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b0;
    check("R7 ready back", in_ready, 1);
    check("R7 no extra bit", out_valid, 0);
  endtask

  task automatic t_reset;
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);
  endtask

  task automatic t_block(input logic [K-1:0] u, input bit stall, input bit junk);
    send_block(u);
    recv_block(u, stall, junk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_block(8'h00, 0, 0);
        t_block(8'hFF, 0, 0);   // R9: previous state must not leak
        t_block(8'h55, 0, 0);
        t_block(8'hB3, 1, 0);   // R8 stalls
        t_block(8'h6C, 0, 1);   // R6 junk during readout
        t_block(8'h01, 0, 0);   // R9 after junk
        t_block(8'h80, 1, 1);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule